// File: doc/BRIEF.md
# Memory Reset and Ready Sequencer

This block puts an external memory device through a reset and then follows its return to service. A single-cycle request starts a sequence. The request chooses between two kinds of reset:

- a hardware reset, where the block drives the device's active-low reset pin low for a minimum pulse width;
- a command reset, where the block raises a one-cycle strobe that tells the surrounding bus logic to issue the reset command.

The moment the pin is released, or the strobe fires, is the latch point. Every later interval is measured from there.

Two readiness results come out of a sequence, and each is tracked separately:

- **Boot-memory readiness** is a fixed interval after the latch point.
- **Core readiness** comes from the device's interrupt status bit, read through a status input. The raw interrupt pin is not used because its timing depends on external pull resistors.

The longest time the core may take depends on the internal operation that the reset interrupted. The requester supplies that activity as a 2-bit code along with the request. If the status bit has not appeared when the selected limit runs out, a timeout error is raised instead of core readiness.

All intervals are whole clock cycles, derived from a clock-frequency parameter in kHz and rounded up. There is no data stream through the block. Every pin is a plain level or a single-cycle strobe, with no back-pressure. Requests that arrive while a sequence is running are dropped.

Top module: `mem_reset_sequencer`

## Requirements
- R1: After reset, mem_rst_n is 1 and cmd_strobe, busy, boot_ready, core_ready and timeout_err are all 0.
- R2: A request with req_cmd=0 drives mem_rst_n low from the request edge for exactly RP cycles (200 ns rounded up to whole cycles). It then returns high, and that edge is the latch point.
- R3: A request with req_cmd=1 raises cmd_strobe for exactly one cycle at the request edge, which is the latch point. mem_rst_n stays high throughout.
- R4: boot_ready rises exactly BOOT cycles (5 us) after the latch point and stays high until the next sequence starts.
- R5: During the wait phase, core_ready rises one cycle after int_status is sampled high. A high int_status while the pin pulse is still running has no effect.
- R6: The core limit is chosen from the activity code: 2'b00 idle and 2'b01 load give 10 us, 2'b10 program gives 20 us, 2'b11 erase gives 500 us. If int_status has not been seen by then, timeout_err rises exactly LIMIT cycles after the latch point, and core_ready stays 0.
- R7: The activity code is captured at the request edge. Changing the activity input later does not change the limit for that sequence.
- R8: Requests made while busy is 1 are ignored: no strobe, no pulse, and no change to the running sequence.
- R9: busy is 1 from the request edge until one cycle after boot_ready is high and either core_ready or timeout_err is high. Starting a new sequence clears boot_ready, core_ready and timeout_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| req | input | 1 | Single-cycle request that starts a reset sequence |
| req_cmd | input | 1 | Reset kind for the request: 1 is a command reset, 0 is a pin pulse |
| activity | input | 2 | Activity the device is running at request time: 00 idle, 01 load, 10 program, 11 erase |
| int_status | input | 1 | Interrupt status bit read back from the device |
| mem_rst_n | output | 1 | Active-low hardware reset pin to the device |
| cmd_strobe | output | 1 | One-cycle pulse that asks the bus logic to send the reset command |
| busy | output | 1 | A sequence is in progress |
| boot_ready | output | 1 | Boot memory is accessible |
| core_ready | output | 1 | The device core reported ready |
| timeout_err | output | 1 | The core did not report ready within the selected limit |

## Verification
The embedded assertions check the following on every cycle:
- the command strobe is one cycle wide and never overlaps the pin pulse;
- the pin pulse never outlasts its count;
- core readiness only ever follows a sampled status bit;
- core readiness and timeout are mutually exclusive;
- the captured activity code holds steady while a sequence runs;
- busy only falls once both results are settled.

The exact cycle counts need the bench's directed scenarios to show them. These are the pulse width, the boot interval, and each of the three core limits. The scenarios also show that a changed activity input or a repeated request is ignored mid-sequence, and that the flags are cleared at the next request.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'b00,
    ACT_LOAD  = 2'b01,
    ACT_PROG  = 2'b10,
    ACT_ERASE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PULSE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_e;

  // Whole cycles covering a duration in ns at a clock in kHz, rounded up, never 0.
  function automatic int ns_to_cycles(input longint ns, input longint khz);
    longint c;
    c = (ns * khz + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/mrs_pulse_gen.sv
module mrs_pulse_gen #(
  parameter int RP_CYC = 50,
  localparam int CW = $clog2(RP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pin_n,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_n <= 1'b1;
      cnt   <= '0;
    end else if (start) begin
      pin_n <= 1'b0;
      cnt   <= CW'(RP_CYC - 1);
    end else if (!pin_n) begin
      if (cnt == '0) pin_n <= 1'b1;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign last = !pin_n && (cnt == '0);

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_n |-> (cnt < CW'(RP_CYC)));

endmodule

// File: rtl/mrs_limit_sel.sv
module mrs_limit_sel import mrs_pkg::*; #(
  parameter int TW        = 17,
  parameter int LIM_IDLE  = 2500,
  parameter int LIM_PROG  = 5000,
  parameter int LIM_ERASE = 125000
) (
  input  act_e          act,
  output logic [TW-1:0] limit
);
  always_comb begin
    case (act)
      ACT_PROG:  limit = TW'(LIM_PROG);
      ACT_ERASE: limit = TW'(LIM_ERASE);
      default:   limit = TW'(LIM_IDLE);
    endcase
  end
endmodule

// File: rtl/mrs_interval_timer.sv
module mrs_interval_timer #(
  parameter int TW       = 17,
  parameter int BOOT_CYC = 1250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          boot_hit,
  output logic          limit_hit
);
  logic [TW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (en)  count <= count + 1'b1;
  end

  assign boot_hit  = en && (count == TW'(BOOT_CYC - 1));
  assign limit_hit = en && (count == limit - 1'b1);

endmodule

// File: rtl/mem_reset_sequencer.sv
module mem_reset_sequencer import mrs_pkg::*; #(
  parameter int CLK_KHZ    = 250000,
  parameter int RP_NS      = 200,
  parameter int BOOT_NS    = 5000,
  parameter int IDLE_NS    = 10000,
  parameter int PROG_NS    = 20000,
  parameter int ERASE_NS   = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_cmd,
  input  logic [1:0] activity,
  input  logic       int_status,
  output logic       mem_rst_n,
  output logic       cmd_strobe,
  output logic       busy,
  output logic       boot_ready,
  output logic       core_ready,
  output logic       timeout_err
);
  localparam int RP_CYC    = ns_to_cycles(RP_NS, CLK_KHZ);
  localparam int BOOT_CYC  = ns_to_cycles(BOOT_NS, CLK_KHZ);
  localparam int LIM_IDLE  = ns_to_cycles(IDLE_NS, CLK_KHZ);
  localparam int LIM_PROG  = ns_to_cycles(PROG_NS, CLK_KHZ);
  localparam int LIM_ERASE = ns_to_cycles(ERASE_NS, CLK_KHZ);
  localparam int MAX_A     = (LIM_IDLE > LIM_PROG) ? LIM_IDLE : LIM_PROG;
  localparam int MAX_B     = (LIM_ERASE > BOOT_CYC) ? LIM_ERASE : BOOT_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW        = $clog2(MAX_CYC + 2);

  seq_e          state;
  act_e          act_q;
  logic          start, pulse_start, pulse_last, enter_wait;
  logic          boot_hit, limit_hit;
  logic [TW-1:0] limit;

  assign start       = (state == SQ_IDLE) && req;
  assign pulse_start = start && !req_cmd;
  assign enter_wait  = (start && req_cmd) || ((state == SQ_PULSE) && pulse_last);
  assign busy        = (state != SQ_IDLE);

  mrs_pulse_gen #(.RP_CYC(RP_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pulse_start),
    .pin_n (mem_rst_n),
    .last  (pulse_last)
  );

  mrs_limit_sel #(
    .TW(TW), .LIM_IDLE(LIM_IDLE), .LIM_PROG(LIM_PROG), .LIM_ERASE(LIM_ERASE)
  ) u_limit (
    .act   (act_q),
    .limit (limit)
  );

  mrs_interval_timer #(.TW(TW), .BOOT_CYC(BOOT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (enter_wait),
    .en        (state == SQ_WAIT),
    .limit     (limit),
    .boot_hit  (boot_hit),
    .limit_hit (limit_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      act_q       <= ACT_IDLE;
      cmd_strobe  <= 1'b0;
      boot_ready  <= 1'b0;
      core_ready  <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      case (state)
        SQ_IDLE: if (req) begin
          act_q       <= act_e'(activity);
          boot_ready  <= 1'b0;
          core_ready  <= 1'b0;
          timeout_err <= 1'b0;
          if (req_cmd) begin
            cmd_strobe <= 1'b1;
            state      <= SQ_WAIT;
          end else begin
            state <= SQ_PULSE;
          end
        end
        SQ_PULSE: if (pulse_last) state <= SQ_WAIT;
        SQ_WAIT: begin
          if (boot_hit) boot_ready <= 1'b1;
          if (!core_ready && !timeout_err) begin
            if (int_status)     core_ready  <= 1'b1;
            else if (limit_hit) timeout_err <= 1'b1;
          end
          if (boot_ready && (core_ready || timeout_err)) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  // R3
  strobe_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> mem_rst_n);

  // R5
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ready) |-> $past(int_status));

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_ready && timeout_err));

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act_q));

  // R9
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (boot_ready && (core_ready || timeout_err)));

endmodule

// File: tb/test_mem_reset_sequencer.sv
module test_mem_reset_sequencer;
  localparam int KHZ  = 10000;   // scaled clock: RP=2, BOOT=50, limits 100/200/5000
  localparam int RP   = 2;
  localparam int BOOT = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_cmd = 1'b0, int_status = 1'b0;
  logic [1:0] activity = 2'b00;
  logic mem_rst_n, cmd_strobe, busy, boot_ready, core_ready, timeout_err;

  int cyc = 0;
  int t0 = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mem_reset_sequencer #(.CLK_KHZ(KHZ)) i_mem_reset_sequencer (
    .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd),
    .activity(activity), .int_status(int_status),
    .mem_rst_n(mem_rst_n), .cmd_strobe(cmd_strobe), .busy(busy),
    .boot_ready(boot_ready), .core_ready(core_ready), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic issue(input bit kind, input logic [1:0] act);
    @(negedge clk);
    req = 1'b1; req_cmd = kind; activity = act;
    @(negedge clk);
    req = 1'b0;
    t0 = cyc;
  endtask

  // sel: 0 boot_ready high, 1 timeout_err high, 2 busy low, 3 core_ready high
  task automatic wait_for(input int sel, output int dt);
    bit hit;
    hit = 1'b0;
    for (int i = 0; i < 6000 && !hit; i++) begin
      case (sel)
        0: hit = boot_ready;
        1: hit = timeout_err;
        2: hit = !busy;
        default: hit = core_ready;
      endcase
      if (!hit) @(negedge clk);
    end
    dt = cyc - t0;
  endtask

  task automatic t_reset_state();
    chk(mem_rst_n === 1'b1, "R1 mem_rst_n", mem_rst_n, 1);
    chk({cmd_strobe, busy, boot_ready, core_ready, timeout_err} === 5'b0,
        "R1 outputs", {cmd_strobe, busy, boot_ready, core_ready, timeout_err}, 0);
  endtask

  task automatic t_pin_idle();
    int dt;
    issue(1'b0, 2'b00);
    chk(mem_rst_n === 1'b0, "R2 pin low at request", mem_rst_n, 0);
    chk(busy === 1'b1, "R9 busy at request", busy, 1);
    @(negedge clk);
    int_status = 1'b1;                       // during pulse: must be ignored (R5)
    chk(mem_rst_n === 1'b0, "R2 pin low second cycle", mem_rst_n, 0);
    @(negedge clk);
    int_status = 1'b0;
    chk(mem_rst_n === 1'b1, "R2 pin released after RP", mem_rst_n, 1);
    wait_for(0, dt);
    chk(dt == RP + BOOT, "R4 boot delay after pin", dt, RP + BOOT);
    wait_for(1, dt);
    chk(dt == RP + 100, "R6 idle limit", dt, RP + 100);
    chk(core_ready === 1'b0, "R5 status during pulse ignored", core_ready, 0);
    wait_for(2, dt);
    chk(dt == RP + 101, "R9 busy drop", dt, RP + 101);
  endtask

  task automatic t_cmd_load();
    int dt;
    issue(1'b1, 2'b01);
    chk(cmd_strobe === 1'b1, "R3 strobe", cmd_strobe, 1);
    chk(mem_rst_n === 1'b1, "R3 pin untouched", mem_rst_n, 1);
    @(negedge clk);
    chk(cmd_strobe === 1'b0, "R3 strobe one cycle", cmd_strobe, 0);
    while (cyc < t0 + 30) @(negedge clk);
    int_status = 1'b1;
    @(negedge clk);
    int_status = 1'b0;
    chk(core_ready === 1'b1 && cyc - t0 == 31, "R5 core ready one cycle after status",
        core_ready, 1);
    wait_for(0, dt);
    chk(dt == BOOT, "R4 boot delay after command", dt, BOOT);
    wait_for(2, dt);
    chk(dt == BOOT + 1, "R9 busy drop after boot", dt, BOOT + 1);
    repeat (5) @(negedge clk);
    chk(boot_ready === 1'b1, "R4 boot held", boot_ready, 1);
    chk(timeout_err === 1'b0, "R6 no timeout when ready", timeout_err, 0);
  endtask

  task automatic t_cmd_prog();
    int dt;
    issue(1'b1, 2'b10);
    wait_for(1, dt);
    chk(dt == 200, "R6 program limit", dt, 200);
    wait_for(2, dt);
  endtask

  task automatic t_cmd_erase();
    int dt;
    issue(1'b1, 2'b11);
    activity = 2'b00;                        // R7: later change has no effect
    repeat (4) @(negedge clk);
    req = 1'b1; req_cmd = 1'b1;              // R8: request while busy
    @(negedge clk);
    req = 1'b0;
    chk(cmd_strobe === 1'b0, "R8 no strobe while busy", cmd_strobe, 0);
    chk(mem_rst_n === 1'b1, "R8 no pulse while busy", mem_rst_n, 1);
    wait_for(1, dt);
    chk(dt == 5000, "R7 erase limit kept", dt, 5000);
    wait_for(2, dt);
  endtask

  task automatic t_reclear();
    int dt;
    chk(timeout_err === 1'b1, "R9 flag held before new request", timeout_err, 1);
    issue(1'b0, 2'b01);
    chk({boot_ready, core_ready, timeout_err} === 3'b0, "R9 flags cleared",
        {boot_ready, core_ready, timeout_err}, 0);
    wait_for(1, dt);
    chk(dt == RP + 100, "R6 load limit", dt, RP + 100);
    wait_for(2, dt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_pin_idle();
    t_cmd_load();
    t_cmd_prog();
    t_cmd_erase();
    t_reclear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule